// File: doc/BRIEF.md
# Shared-Bus Multi-Converter Read Sequencer

This block runs a group of four parallel-output analog-to-digital converters that sit on one common tri-state data bus. A periodic start tick opens a frame. The block then raises one conversion-start pulse for the whole group and gives each converter its own read strobe in turn, device 0 first. Each result is latched from the shared bus into a register for that device. After the last capture a one-cycle frame-valid pulse tells downstream logic that all four results are current.

A frame takes ten clock periods from the conversion-start cycle through the frame-valid cycle. At a 40 ns clock this meets a 400 ns frame budget. Two strobe shapes are available, and the shape is chosen once per frame:

- Conservative mode holds a strobe for one full clock and then leaves a full idle clock for the bus to release.
- Overlapped mode holds a strobe for one and a half clocks and drops it at the falling clock edge. This leaves only a half-clock gap, so the next device starts driving while the previous one may still be releasing. That costs no data, because nothing is captured in that window.

A start tick that arrives while a frame is running is dropped and recorded in a sticky overrun flag.

States of the controller:

| State | Meaning |
|---|---|
| `S_IDLE` | Waiting for a tick. |
| `S_CONV` | Conversion-start cycle. |
| `S_STROBE` | First full clock of the current device's strobe. |
| `S_GAP` | Bus-release clock. In overlapped mode its first half still carries the strobe. |
| `S_DONE` | Frame-valid cycle. |

Transitions of the controller:

| From | To | Condition |
|---|---|---|
| `S_IDLE` | `S_CONV` | A tick arrives. |
| `S_CONV` | `S_STROBE` | Always. |
| `S_STROBE` | `S_GAP` | Always. |
| `S_GAP` | `S_STROBE` | Devices remain. The device index advances. |
| `S_GAP` | `S_DONE` | The last device has been read. |
| `S_DONE` | `S_CONV` | A tick arrives. |
| `S_DONE` | `S_IDLE` | No tick arrives. |

Top module: `adc_bus_sequencer`

## Requirements
- R1: During and after reset, all read strobes, conversion start, frame valid and overrun are 0, and every result register reads 0.
- R2: A start tick sampled high in `S_IDLE` or `S_DONE` makes conversion start high for exactly the next clock period. The mode input is latched at that same edge (1 = overlapped, 0 = conservative).
- R3: In conservative mode, device k's strobe (bit k of the strobe port) is high for exactly one clock and is followed by one full low clock. Device 0 rises on the rising edge that ends the conversion-start cycle, and devices run in order 0, 1, 2, 3.
- R4: In overlapped mode each strobe rises on a rising edge, stays high for one and a half clocks, falls on a falling edge, and the next device's strobe rises half a clock later.
- R5: At most one read strobe is high at any rising or falling clock edge, in either mode.
- R6: Result k (bits k*DATA_W upward of the result port) takes the bus value present at the rising edge that ends the first full clock of device k's strobe. Bus values at any other time do not reach it.
- R7: Frame valid is a one-cycle pulse that rises 9 clocks after conversion start rose. A tick in that frame-valid cycle starts the next frame at once, so a tick every 10 clocks is served without overrun.
- R8: A tick sampled while a frame is in progress (`S_CONV`, `S_STROBE`, `S_GAP`) starts no frame and sets overrun, which stays 1 until reset.
- R9: Changing the mode input during a frame does not change that frame's strobe shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; both edges are used. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| start_tick | input | 1 | Periodic frame request. |
| fast_mode | input | 1 | 1 selects overlapped strobes; sampled at frame start. |
| bus_data | input | DATA_W | Shared converter data bus. |
| conv_start | output | 1 | Group conversion-start pulse. |
| rd_strobe | output | N_DEV | Per-device read enables, bit k for device k. |
| results | output | N_DEV*DATA_W | Captured results, device k in slice k. |
| frame_valid | output | 1 | One-cycle pulse when all results are fresh. |
| overrun | output | 1 | Sticky flag for a tick that was dropped. |

## Verification
Each kind of wrong internal state shows up at the ports within one frame:

- A wrong device index shows as a result landing in the wrong slice. The scoreboard catches it at the next frame-valid pulse, at most ten clocks later.
- A wrong state sequence shows as a strobe of the wrong width or a gap of the wrong length. It is measured in half-clock steps and reported when the frame closes.
- A wrong mode latch shows as the strobe shape changing inside a frame.
- A mistimed half-clock register shows as two strobes high in the same half period, which the bench catches at that half period.
- A wrong busy decode shows as an extra frame-valid pulse or a missing overrun flag once the tick test finishes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CONV   = 3'd1,
        S_STROBE = 3'd2,
        S_GAP    = 3'd3,
        S_DONE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_tick,
    input  logic             mode_in,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             fast_o,
    output logic             overrun_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DEV - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             fast_q;
    logic             ovr_q;
    logic             open_slot;
    logic             accept;

    // A tick is welcome only when no frame is mid-flight.
    assign open_slot = (state_q == S_IDLE) || (state_q == S_DONE);
    assign accept    = start_tick && open_slot;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = start_tick ? S_CONV : S_IDLE;
            S_CONV:   state_d = S_STROBE;
            S_STROBE: state_d = S_GAP;
            S_GAP:    state_d = (idx_q == LAST_IDX) ? S_DONE : S_STROBE;
            S_DONE:   state_d = start_tick ? S_CONV : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Device pointer: cleared at frame start, advanced after each gap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == S_CONV) begin
            idx_q <= '0;
        end else if (state_q == S_GAP && idx_q != LAST_IDX) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Mode is frozen for the frame at the accepting edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (accept) begin
            fast_q <= mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (start_tick && !open_slot) begin
            ovr_q <= 1'b1;
        end
    end

    assign state_o   = state_q;
    assign idx_o     = idx_q;
    assign fast_o    = fast_q;
    assign overrun_o = ovr_q;

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import adc_seq_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             fast_i,
    output logic [N_DEV-1:0] rd_o,
    output logic             conv_o,
    output logic             valid_o,
    output logic             cap_o
);

    // Set at the falling edge inside a gap cycle; cuts the extended strobe.
    logic late_half_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            late_half_q <= 1'b0;
        end else begin
            late_half_q <= (state_i == S_GAP);
        end
    end

    always_comb begin
        logic hold;
        hold    = (state_i == S_STROBE) ||
                  (fast_i && state_i == S_GAP && !late_half_q);
        conv_o  = (state_i == S_CONV);
        valid_o = (state_i == S_DONE);
        cap_o   = (state_i == S_STROBE);
        for (int k = 0; k < N_DEV; k++) begin
            rd_o[k] = hold && (idx_i == IDX_W'(k));
        end
    end

endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
    parameter int N_DEV  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [DATA_W-1:0]       bus_i,
    output logic [N_DEV*DATA_W-1:0] res_o
);

    for (genvar g = 0; g < N_DEV; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (cap_i && idx_i == IDX_W'(g)) begin
                slot_q <= bus_i;
            end
        end

        assign res_o[g*DATA_W +: DATA_W] = slot_q;
    end

endmodule

// File: rtl/adc_bus_sequencer.sv
module adc_bus_sequencer
    import adc_seq_pkg::*;
#(
    parameter int N_DEV  = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_tick,
    input  logic                    fast_mode,
    input  logic [DATA_W-1:0]       bus_data,
    output logic                    conv_start,
    output logic [N_DEV-1:0]        rd_strobe,
    output logic [N_DEV*DATA_W-1:0] results,
    output logic                    frame_valid,
    output logic                    overrun
);

    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

    seq_state_e       st;
    logic [IDX_W-1:0] idx;
    logic             fast_lat;
    logic             cap_en;

    seq_fsm #(.N_DEV(N_DEV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_tick(start_tick),
        .mode_in   (fast_mode),
        .state_o   (st),
        .idx_o     (idx),
        .fast_o    (fast_lat),
        .overrun_o (overrun)
    );

    strobe_gen #(.N_DEV(N_DEV)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_i(st),
        .idx_i  (idx),
        .fast_i (fast_lat),
        .rd_o   (rd_strobe),
        .conv_o (conv_start),
        .valid_o(frame_valid),
        .cap_o  (cap_en)
    );

    capture_bank #(.N_DEV(N_DEV), .DATA_W(DATA_W)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .cap_i(cap_en),
        .idx_i(idx),
        .bus_i(bus_data),
        .res_o(results)
    );

endmodule

// File: rtl/adc_bus_sequencer_chk.sv
module adc_bus_sequencer_chk #(
    parameter int N_DEV  = 4,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    conv_start,
    input logic [N_DEV-1:0]        rd_strobe,
    input logic [N_DEV*DATA_W-1:0] results,
    input logic                    frame_valid,
    input logic                    overrun
);

    p_one_strobe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_strobe));

    p_one_strobe_fall_r5: assert property (@(negedge clk) disable iff (!rst_n)
        $onehot0(rd_strobe));

    p_conv_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_first_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> rd_strobe[0]);

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_capture_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (results != $past(results)) |-> $past(|rd_strobe));

endmodule

bind adc_bus_sequencer adc_bus_sequencer_chk #(.N_DEV(N_DEV), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .rd_strobe  (rd_strobe),
    .results    (results),
    .frame_valid(frame_valid),
    .overrun    (overrun)
);

// File: tb/adc_bus_sequencer_bench.sv
`timescale 1ns/1ps
module adc_bus_sequencer_bench;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int HP = 4;

    typedef struct {
        bit           fast;
        logic [N*W-1:0] vals;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_tick = 1'b0;
    logic           fast_mode = 1'b0;
    logic [W-1:0]   bus_data;
    logic           conv_start;
    logic [N-1:0]   rd_strobe;
    logic [N*W-1:0] results;
    logic           frame_valid;
    logic           overrun;

    logic [N*W-1:0] dev_val = '0;
    logic [N-1:0]   seen_hi = '0;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb_q[$];

    int   run_len[N];
    int   last_len[N];
    int   gap_len[N];
    int   gap_cnt = 0;
    int   cyc = 0;
    int   conv_cyc = 0;
    int   overlap_hits = 0;

    always #(HP) clk = ~clk;

    adc_bus_sequencer u_adc_bus_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_tick (start_tick),
        .fast_mode  (fast_mode),
        .bus_data   (bus_data),
        .conv_start (conv_start),
        .rd_strobe  (rd_strobe),
        .results    (results),
        .frame_valid(frame_valid),
        .overrun    (overrun)
    );

    // Converter model: true data only during the first clock of a strobe,
    // inverted data after that, zero when nobody drives.
    always @(posedge clk) seen_hi <= rd_strobe;

    always_comb begin
        bus_data = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_strobe[k]) begin
                bus_data = seen_hi[k] ? ~dev_val[k*W +: W] : dev_val[k*W +: W];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Measure strobe widths and gaps in half-clock units.
    task automatic half_sample();
        if ($countones(rd_strobe) > 1) overlap_hits++;
        if (rd_strobe == '0) gap_cnt++;
        for (int k = 0; k < N; k++) begin
            if (rd_strobe[k]) begin
                if (run_len[k] == 0) begin
                    gap_len[k] = gap_cnt;
                    gap_cnt    = 0;
                end
                run_len[k]++;
            end else if (run_len[k] > 0) begin
                last_len[k] = run_len[k];
                run_len[k]  = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n) half_sample();
    end

    // Monitor: pops the scoreboard on each frame-valid pulse.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            half_sample();
            if (conv_start) begin
                conv_cyc = cyc;
                gap_cnt  = 0;
            end
            if (frame_valid) begin
                check(cyc - conv_cyc == 9, "R7", "conv-to-valid clocks",
                      cyc - conv_cyc, 9);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected frame", 1, 0);
                end else begin
                    exp_t e;
                    int   wexp;
                    int   gexp;
                    e = sb_q.pop_front();
                    for (int k = 0; k < N; k++) begin
                        check(results[k*W +: W] == e.vals[k*W +: W], "R6",
                              $sformatf("result dev%0d", k),
                              results[k*W +: W], e.vals[k*W +: W]);
                    end
                    wexp = e.fast ? 3 : 2;
                    gexp = e.fast ? 1 : 2;
                    for (int k = 0; k < N; k++) begin
                        check(last_len[k] == wexp, e.fast ? "R4 R9" : "R3",
                              $sformatf("strobe halves dev%0d", k),
                              last_len[k], wexp);
                    end
                    for (int k = 1; k < N; k++) begin
                        check(gap_len[k] == gexp, e.fast ? "R4 R9" : "R3",
                              $sformatf("gap halves before dev%0d", k),
                              gap_len[k], gexp);
                    end
                end
            end
        end
    end

    // Driver: one tick at a negedge, expected frame pushed.
    task automatic drive_frame(input bit fast, input logic [N*W-1:0] vals);
        exp_t e;
        dev_val    = vals;
        fast_mode  = fast;
        e.fast     = fast;
        e.vals     = vals;
        sb_q.push_back(e);
        start_tick = 1'b1;
        @(negedge clk);
        start_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < N; k++) begin
            run_len[k]  = 0;
            last_len[k] = 0;
            gap_len[k]  = 0;
        end
        repeat (3) @(negedge clk);

        // R1: reset state
        check(rd_strobe == '0 && !conv_start && !frame_valid && !overrun,
              "R1", "control outputs in reset",
              {rd_strobe, conv_start, frame_valid, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(results == '0, "R1", "results after reset", results, 0);

        // R2: single-cycle conversion start after a tick
        drive_frame(1'b0, 64'h1111_2222_3333_4444);
        check(conv_start == 1'b1, "R2", "conv_start after tick", conv_start, 1);
        @(negedge clk);
        check(conv_start == 1'b0, "R2", "conv_start width", conv_start, 0);
        check(rd_strobe == 4'b0001, "R3", "dev0 strobe follows conv",
              rd_strobe, 4'b0001);
        repeat (12) @(negedge clk);

        // R4: overlapped frame
        drive_frame(1'b1, 64'hA5A5_0F0F_F00F_5A5A);
        repeat (12) @(negedge clk);

        // R7: back-to-back ticks every 10 clocks, alternating modes
        drive_frame(1'b0, 64'h0001_0203_0405_0607);
        repeat (9) @(negedge clk);
        drive_frame(1'b1, 64'hFFFF_0000_FFFF_0000);
        repeat (9) @(negedge clk);
        drive_frame(1'b0, 64'h1234_5678_9ABC_DEF0);
        repeat (12) @(negedge clk);
        check(overrun == 1'b0, "R7", "no overrun at 10-clock period", overrun, 0);
        check(sb_q.size() == 0, "R7", "all frames delivered", sb_q.size(), 0);

        // R9: mode input changed mid-frame
        drive_frame(1'b1, 64'hCAFE_BEEF_0BAD_F00D);
        repeat (3) @(negedge clk);
        fast_mode = 1'b0;
        repeat (10) @(negedge clk);

        // R8: tick while busy is dropped, overrun sticks
        drive_frame(1'b0, 64'h7777_8888_9999_AAAA);
        repeat (3) @(negedge clk);
        start_tick = 1'b1;
        @(negedge clk);
        start_tick = 1'b0;
        check(overrun == 1'b1, "R8", "overrun after busy tick", overrun, 1);
        repeat (25) @(negedge clk);
        check(sb_q.size() == 0, "R8", "busy tick made no frame", sb_q.size(), 0);
        check(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);

        // R5: exclusion sampled every half clock over all frames
        check(overlap_hits == 0, "R5", "half-periods with two strobes",
              overlap_hits, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule